// File: doc/BRIEF.md
# Windowed error-rate penalty generator

This block sits beside a learning voltage controller. Each clock it receives one flag that marks a cycle with a timing error. It counts these flags over a window whose length in cycles is programmable. At the end of each window it turns the error count into a penalty value, which the controller subtracts when it scores the last voltage move.

The rate is never divided out. The count is scaled by 2^16 and compared with the limit times the window length. The limit is the error bound less a safety margin, both given as fractions of 2^16. Below the limit the penalty is a small constant floor. At or above the limit the penalty is the current action's reward times a fixed scale. In graded mode a linear ramp joins these two levels. The ramp ends at the reward-scaled value at the limit and is cut off at the floor.

The penalty and the count are registered at each window end and then held. A one-clock pulse marks each update.

Top module: `err_penalty_gen`

## Requirements
- R1: The block counts cycles with `err_i` high over a window of W = `win_len_i` cycles. A value of 0 acts as W = 1. Windows follow each other with no gap. At the end of each window, `rate_o` takes the error count of the window that just ended.
- R2: `done_o` is high for exactly one clock, in the cycle after the last cycle of a window. `rate_o` and `pen_o` take their new values in that same cycle. All inputs are sampled in the last cycle of the window.
- R3: After reset, `rate_o` = 0, `pen_o` = EPS (default 1) and `done_o` = 0. `pen_o` and `rate_o` do not change in any cycle in which `done_o` is low.
- R4: The limit is T = `bound_i` − `margin_i`, or 0 if the margin is larger. Both inputs are fractions of 2^16. The rate counts as at or above the limit when count·2^16 ≥ T·W.
- R5: Abrupt mode (`mode_i` = 0) with positive reward:
  - below the limit, `pen_o` = EPS;
  - at or above the limit, `pen_o` = SIGMA·`reward_i` (default SIGMA = 3).
- R6: Graded mode (`mode_i` = 1) with positive reward:
  - at or above the limit, `pen_o` = SIGMA·`reward_i`;
  - below the limit, `pen_o` = max(EPS, SIGMA·`reward_i` − floor(`gamma_i`·(T·W − count·2^16)/2^16)).
- R7: When `reward_i` ≤ 0 (two's complement), `pen_o` = EPS in both modes.
- R8: `pen_o` always lies between EPS and SIGMA·reward of its window, inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_i | input | 1 | Timing error seen in this cycle |
| win_len_i | input | 16 | Window length in cycles (0 acts as 1) |
| bound_i | input | 16 | Error rate bound, fraction of 2^16 |
| margin_i | input | 16 | Safety margin, fraction of 2^16 |
| gamma_i | input | 8 | Ramp slope, in penalty units per error of deficit |
| reward_i | input | 16 | Signed reward of the current action |
| mode_i | input | 1 | 0 abrupt, 1 graded |
| pen_o | output | 20 | Signed penalty, held between window ends |
| rate_o | output | 16 | Error count of the last finished window |
| done_o | output | 1 | One-clock pulse on each new result |

## Verification
Some rules are checked by assertions on every cycle:
- the error count never passes the cycle count of its window;
- the outputs hold whenever no pulse is present;
- the floor and the reward-scaled ceiling always bound the penalty;
- any non-positive reward produces the floor.

Other behaviour can only be shown by the bench's scenarios:
- the exact threshold crossing, where a count that meets the limit exactly must give the full penalty;
- the slope and cut-off of the ramp;
- window lengths of zero and one;
- the alignment of results when the window length changes mid-window.

// File: rtl/err_penalty_pkg.sv
package err_penalty_pkg;
  typedef enum logic {
    PEN_ABRUPT = 1'b0,
    PEN_GRADED = 1'b1
  } pen_mode_e;
endpackage

// File: rtl/err_window_counter.sv
module err_window_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_i,
  input  logic [CNT_W-1:0] wlen_i,
  output logic             last_o,
  output logic [CNT_W-1:0] total_o
);
  logic [CNT_W-1:0] cyc_q, cnt_q;

  assign last_o  = cyc_q >= (wlen_i - CNT_W'(1));
  assign total_o = cnt_q + CNT_W'(err_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      cnt_q <= '0;
    end else if (last_o) begin
      cyc_q <= '0;
      cnt_q <= '0;
    end else begin
      cyc_q <= cyc_q + CNT_W'(1);
      cnt_q <= total_o;
    end
  end

  // errors never outnumber elapsed cycles of the window (R1)
  p_cnt_le_cyc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= cyc_q);
endmodule

// File: rtl/penalty_calc.sv
module penalty_calc
  import err_penalty_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 16,
  parameter int VAL_W  = 16,
  parameter int GAM_W  = 8,
  parameter int SIG_W  = 4,
  parameter int SIGMA  = 3,
  parameter int EPS    = 1,
  localparam int PEN_W = VAL_W + SIG_W
) (
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [CNT_W-1:0]        wlen_i,
  input  logic [FRAC_W-1:0]       bound_i,
  input  logic [FRAC_W-1:0]       margin_i,
  input  logic [GAM_W-1:0]        gamma_i,
  input  logic signed [VAL_W-1:0] reward_i,
  input  pen_mode_e               mode_i,
  output logic signed [PEN_W-1:0] pen_o
);
  localparam int PROD_W = CNT_W + FRAC_W;
  localparam int RAMP_W = PROD_W + GAM_W;
  localparam int DROP_W = RAMP_W - FRAC_W;
  localparam int WIDE_W = ((PEN_W > DROP_W) ? PEN_W : DROP_W) + 1;

  logic [FRAC_W-1:0]       thr;
  logic [PROD_W-1:0]       lhs, rhs, deficit;
  logic [RAMP_W-1:0]       ramp;
  logic [DROP_W-1:0]       drop;
  logic                    above, floored;
  logic signed [PEN_W-1:0] rew_x, sig_x, sr, eps_x;

  assign thr     = (bound_i > margin_i) ? bound_i - margin_i : '0;
  assign lhs     = {cnt_i, {FRAC_W{1'b0}}};
  assign rhs     = PROD_W'(thr) * PROD_W'(wlen_i);
  assign above   = lhs >= rhs;
  assign deficit = rhs - lhs;
  assign ramp    = RAMP_W'(deficit) * RAMP_W'(gamma_i);
  assign drop    = ramp[RAMP_W-1:FRAC_W];

  assign rew_x = {{SIG_W{reward_i[VAL_W-1]}}, reward_i};
  assign sig_x = PEN_W'(SIGMA);
  assign eps_x = PEN_W'(EPS);
  assign sr    = rew_x * sig_x;
  // ramp value at or under the floor
  assign floored = (WIDE_W'(drop) + WIDE_W'(EPS)) >= WIDE_W'(unsigned'(sr));

  always_comb begin
    if (rew_x <= 0)               pen_o = eps_x;
    else if (above)               pen_o = sr;
    else if (mode_i == PEN_ABRUPT) pen_o = eps_x;
    else if (floored)             pen_o = eps_x;
    else                          pen_o = sr - PEN_W'(drop);
  end
endmodule

// File: rtl/err_penalty_gen.sv
module err_penalty_gen
  import err_penalty_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 16,
  parameter int VAL_W  = 16,
  parameter int GAM_W  = 8,
  parameter int SIG_W  = 4,
  parameter int SIGMA  = 3,
  parameter int EPS    = 1,
  localparam int PEN_W = VAL_W + SIG_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    err_i,
  input  logic [CNT_W-1:0]        win_len_i,
  input  logic [FRAC_W-1:0]       bound_i,
  input  logic [FRAC_W-1:0]       margin_i,
  input  logic [GAM_W-1:0]        gamma_i,
  input  logic signed [VAL_W-1:0] reward_i,
  input  logic                    mode_i,
  output logic signed [PEN_W-1:0] pen_o,
  output logic [CNT_W-1:0]        rate_o,
  output logic                    done_o
);
  logic [CNT_W-1:0]        wlen_eff, total;
  logic                    last;
  logic signed [PEN_W-1:0] pen_d;
  pen_mode_e               mode;

  assign wlen_eff = (win_len_i == '0) ? CNT_W'(1) : win_len_i;
  assign mode     = pen_mode_e'(mode_i);

  err_window_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .err_i   (err_i),
    .wlen_i  (wlen_eff),
    .last_o  (last),
    .total_o (total)
  );

  penalty_calc #(
    .CNT_W(CNT_W), .FRAC_W(FRAC_W), .VAL_W(VAL_W), .GAM_W(GAM_W),
    .SIG_W(SIG_W), .SIGMA(SIGMA), .EPS(EPS)
  ) u_calc (
    .cnt_i    (total),
    .wlen_i   (wlen_eff),
    .bound_i  (bound_i),
    .margin_i (margin_i),
    .gamma_i  (gamma_i),
    .reward_i (reward_i),
    .mode_i   (mode),
    .pen_o    (pen_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pen_o  <= PEN_W'(EPS);
      rate_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= last;
      if (last) begin
        pen_o  <= pen_d;
        rate_o <= total;
      end
    end
  end

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(pen_o) && $stable(rate_o)));

  p_floor_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pen_o >= PEN_W'(EPS));

  p_clamp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ($past(reward_i) <= 0)) |-> (pen_o == PEN_W'(EPS)));

  p_ceiling_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ($past(reward_i) > 0)) |->
      (pen_o <= PEN_W'(SIGMA) * {{SIG_W{$past(reward_i[VAL_W-1])}}, $past(reward_i)}));
endmodule

// File: tb/err_penalty_gen_tb.sv
module err_penalty_gen_tb;
  localparam int SIGMA = 3;
  localparam int EPS   = 1;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               err = 1'b0;
  logic [15:0]        wlen = 16'd10;
  logic [15:0]        bound = 16'd0;
  logic [15:0]        margin = 16'd0;
  logic [7:0]         gamma = 8'd0;
  logic signed [15:0] reward = 16'sd0;
  logic               mode = 1'b0;
  logic signed [19:0] pen;
  logic [15:0]        rate;
  logic               done;

  int    total = 0, bad = 0;
  string tag = "R3";

  longint m_cyc, m_cnt, e_pen, e_rate;
  bit     e_done;

  always #4 clk = ~clk;

  err_penalty_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .err_i(err), .win_len_i(wlen),
    .bound_i(bound), .margin_i(margin), .gamma_i(gamma),
    .reward_i(reward), .mode_i(mode),
    .pen_o(pen), .rate_o(rate), .done_o(done)
  );

  function automatic longint ref_pen(longint cnt, longint w);
    longint thr, lhs, rhs, sr, p;
    thr = longint'(bound) - longint'(margin);
    if (thr < 0) thr = 0;
    lhs = cnt * 65536;
    rhs = thr * w;
    sr  = SIGMA * longint'(reward);
    if (reward <= 0) return EPS;
    if (lhs >= rhs) return sr;
    if (!mode) return EPS;
    p = sr - (longint'(gamma) * (rhs - lhs)) / 65536;
    return (p < EPS) ? EPS : p;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    longint w, tot;
    if (!rst_n) begin
      m_cyc = 0; m_cnt = 0; e_pen = EPS; e_rate = 0; e_done = 0;
    end else begin
      w   = (wlen == 0) ? 1 : longint'(wlen);
      tot = m_cnt + longint'(err);
      if (m_cyc >= w - 1) begin
        e_done = 1; e_rate = tot; e_pen = ref_pen(tot, w);
        m_cyc = 0; m_cnt = 0;
      end else begin
        e_done = 0; m_cyc++; m_cnt = tot;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    total++;
    if (done !== e_done) begin
      bad++; $display("FAIL R2 done=%0b exp=%0b", done, e_done);
    end else if (longint'(rate) != e_rate) begin
      bad++; $display("FAIL R1 rate=%0d exp=%0d", rate, e_rate);
    end else if (longint'(pen) != e_pen) begin
      bad++; $display("FAIL %s pen=%0d exp=%0d", e_done ? tag : "R3", pen, e_pen);
    end
  end

  // periodic pattern: every run of w cycles holds exactly k errors
  task automatic pattern(int k, int w, int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      err = ((i % w) < k);
    end
  endtask

  task automatic random_run(int pct, int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      err = ($urandom_range(99) < pct);
    end
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (pen !== 20'sd1 || rate !== 16'd0) begin
      bad++; $display("FAIL R3 reset pen=%0d rate=%0d exp=1/0", pen, rate);
    end
    // abrupt, limit 0.25
    tag = "R5"; mode = 0; bound = 16'd19661; margin = 16'd3277; reward = 16'sd100;
    wlen = 10; pattern(2, 10, 60);
    pattern(3, 10, 60);
    // exact limit: 2 of 8 is 0.25 (bound 0.30 - margin 0.05 truncates to 16384)
    tag = "R4"; bound = 16'd20000; margin = 16'd3616;
    wlen = 8; pattern(2, 8, 48);
    pattern(1, 8, 48);
    // graded ramp, limit 0.25, W=16
    tag = "R6"; mode = 1; gamma = 8'd50;
    wlen = 16; pattern(3, 16, 64);
    pattern(0, 16, 64);
    pattern(4, 16, 64);
    gamma = 8'd200; pattern(1, 16, 64);
    // margin larger than bound -> limit 0
    tag = "R4"; margin = 16'd30000; pattern(0, 16, 48);
    margin = 16'd3616;
    // non-positive reward
    tag = "R7"; reward = -16'sd40; pattern(6, 16, 48);
    mode = 0; reward = 16'sd0; pattern(6, 16, 48);
    // zero and unit window
    tag = "R1"; reward = 16'sd77; wlen = 0; random_run(50, 40);
    wlen = 1; random_run(50, 40);
    // long random run, lengths changing mid-window
    tag = "R8";
    for (int r = 0; r < 60; r++) begin
      wlen   = 16'($urandom_range(40));
      bound  = 16'($urandom_range(65535));
      margin = 16'($urandom_range(8000));
      gamma  = 8'($urandom_range(255));
      reward = 16'($urandom_range(65535));
      mode   = $urandom_range(1) == 1;
      random_run($urandom_range(100), 90);
    end
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule